// File: doc/BRIEF.md
# Credit-gated AXI read slave

This block is the read side of an AXI slave placed in front of a packet-based link. A client master presents read addresses on the AR channel. The block takes a request only when the link reports transmit credit and a free slot exists in its table of outstanding split requests. It then gives the request a tag and issues it toward the link side in the same cycle.

The link returns completion words, each labelled with the tag of its request. The block buffers them per tag and replays each request as one unbroken burst on the R channel. Bursts leave in the order their requests were accepted, so they never interleave. A realignment stage places the requested bytes at the lanes that match the low address bits.

Configuration and I/O reads travel the same path. They always come back as one 4-byte beat placed at the request's byte offset.

Top module: `axi_split_rd_slave`

## Requirements
- R1: `ar_ready_o` is high only while `ar_valid_i`, `credit_ok_i` and at least one free table slot are all present. It never stays high for two consecutive cycles. A cycle in which `ar_ready_o` is high accepts one request and uses one credit.
- R2: In the acceptance cycle `req_valid_o` is high. `req_tag_o` is the lowest-numbered free tag, `req_addr_o` equals `ar_addr_i` and `req_kind_o` equals `ar_kind_i`. `req_len_o` equals `ar_len_i` for memory reads and 0 for configuration and I/O reads.
- R3: The table holds `NTAG` (8) entries. With `NTAG` requests outstanding, no request is accepted until the final beat of the oldest burst is taken by the client.
- R4: `proto_err_o` is high in the acceptance cycle of a memory read whose `ar_len_i` is nonzero while `ar_size_i` is not log2 of the bus width in bytes (5 for 256 bits). A legal size gives no flag. The flagged request is still served.
- R5: Bursts appear on R in request acceptance order and never interleave. `r_id_o` carries the `ar_id_i` of the request being served.
- R6: A memory read delivers exactly `ar_len_i`+1 beats. `r_last_o` is high on the final beat only.
- R7: While `r_valid_o` is high and `r_ready_i` is low, `r_valid_o`, `r_data_o`, `r_last_o` and `r_id_o` hold their values.
- R8: Completion word k of a request arrives with the first requested byte in lane 0. With byte offset off = `ar_addr_i[4:0]`, beat k is `(w[k] << 8*off) | (w[k-1] >> (DATA_W-8*off))`, taking w[-1] = 0 and using w[k] alone when off is 0.
- R9: A configuration (`ar_kind_i`=1) or I/O (`ar_kind_i`=2) read yields one beat with `r_last_o` high. The beat's data is `w[0][31:0] << 8*off` with all other bytes zero. `ar_len_i` and `ar_size_i` are ignored for these reads. Kind 0 (and 3) are memory reads.
- R10: `r_resp_o` is always 0 (OKAY).
- R11: Completion words for a tag that has no outstanding request, and words beyond the `len`+1 expected for a tag, are discarded.
- R12: While `rst_ni` is low and in the first cycle after reset, `ar_ready_o` and `r_valid_o` are low and the table is empty.
- R13: Beat k is not presented until completion word k of that request has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address accepted (one-cycle pulse) |
| ar_id_i | input | ID_W | Read transaction ID |
| ar_addr_i | input | ADDR_W | Read byte address |
| ar_len_i | input | LEN_W | Beats minus one |
| ar_size_i | input | 3 | Beat size, log2 bytes |
| ar_kind_i | input | 2 | 0 memory, 1 configuration, 2 I/O |
| credit_ok_i | input | 1 | Link transmit credit available |
| proto_err_o | output | 1 | Illegal burst size on accepted request |
| req_valid_o | output | 1 | Tagged request issued to link |
| req_tag_o | output | TAG_W | Tag of issued request |
| req_addr_o | output | ADDR_W | Address of issued request |
| req_len_o | output | LEN_W | Beats minus one of issued request |
| req_kind_o | output | 2 | Kind of issued request |
| cpl_valid_i | input | 1 | Completion word valid |
| cpl_tag_i | input | TAG_W | Tag of completion word |
| cpl_data_i | input | DATA_W | Completion word, packed from lane 0 |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Client ready for read data |
| r_id_o | output | ID_W | Read data ID |
| r_data_o | output | DATA_W | Read data beat |
| r_resp_o | output | 2 | Read response, always OKAY |
| r_last_o | output | 1 | Final beat of burst |

## Verification
A corrupted table entry shows up at R on the first beat of the affected burst. A wrong length moves `r_last_o` or adds or drops beats. A wrong offset misplaces bytes in `r_data_o`, and a wrong ID shows in `r_id_o`. A wrong order queue plays a younger burst ahead of an older one. This appears as soon as the older burst's data is ready, or it stalls R while the younger data sits buffered. A leaked busy flag appears later, as `ar_ready_o` staying low with fewer than eight requests outstanding. A premature free appears as an accepted ninth request. Each of these is visible within a few cycles of the next request or completion that touches the entry.

// File: rtl/axi_rd_pkg.sv
package axi_rd_pkg;
  typedef enum logic [1:0] {
    KIND_MEM = 2'd0,
    KIND_CFG = 2'd1,
    KIND_IO  = 2'd2,
    KIND_RSV = 2'd3
  } rd_kind_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic is_single(input logic [1:0] kind);
    return (kind == KIND_CFG) || (kind == KIND_IO);
  endfunction
endpackage

// File: rtl/rd_tag_alloc.sv
module rd_tag_alloc #(
  parameter int NTAG  = 8,
  localparam int TAG_W = $clog2(NTAG)
) (
  input  logic [NTAG-1:0]  busy_i,
  output logic             free_o,
  output logic [TAG_W-1:0] tag_o
);
  // lowest free index wins
  always_comb begin
    free_o = 1'b0;
    tag_o  = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        free_o = 1'b1;
        tag_o  = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/rd_order_fifo.sv
module rd_order_fifo #(
  parameter int N = 8,
  parameter int W = 3,
  localparam int PW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] tag_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  logic [W-1:0]  slot_q [N];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wp_q] <= tag_i;
  end

  assign head_o  = slot_q[rp_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rd_cpl_buffer.sv
module rd_cpl_buffer #(
  parameter int NTAG      = 8,
  parameter int MAX_BEATS = 8,
  parameter int DATA_W    = 256,
  localparam int TAG_W    = $clog2(NTAG),
  localparam int LEN_W    = $clog2(MAX_BEATS),
  localparam int DEPTH    = NTAG * MAX_BEATS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [LEN_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TAG_W-1:0]  rtag_i,
  input  logic [LEN_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] cur_o,
  output logic [DATA_W-1:0] prev_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[int'(wtag_i) * MAX_BEATS + int'(widx_i)] <= wdata_i;
  end

  always_comb begin
    cur_o  = mem_q[int'(rtag_i) * MAX_BEATS + int'(ridx_i)];
    prev_o = '0;
    if (ridx_i != '0) prev_o = mem_q[int'(rtag_i) * MAX_BEATS + int'(ridx_i) - 1];
  end
endmodule

// File: rtl/rd_realign.sv
module rd_realign #(
  parameter int DATA_W  = 256,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int SH_W   = OFF_W + 3
) (
  input  logic              single_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] prev_i,
  output logic [DATA_W-1:0] data_o
);
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] dword;

  assign sh    = {off_i, 3'b000};
  assign dword = {{(DATA_W - 32){1'b0}}, cur_i[31:0]};

  always_comb begin
    if (single_i)          data_o = dword << sh;
    else if (off_i == '0)  data_o = cur_i;
    else                   data_o = (cur_i << sh) | (prev_i >> (DATA_W - int'(sh)));
  end
endmodule

// File: rtl/axi_split_rd_slave.sv
module axi_split_rd_slave
  import axi_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 256,
  parameter int NTAG      = 8,
  parameter int MAX_BEATS = 8,
  localparam int TAG_W    = $clog2(NTAG),
  localparam int LEN_W    = $clog2(MAX_BEATS),
  localparam int OFF_W    = $clog2(DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic [LEN_W-1:0]  ar_len_i,
  input  logic [2:0]        ar_size_i,
  input  logic [1:0]        ar_kind_i,
  input  logic              credit_ok_i,
  output logic              proto_err_o,
  output logic              req_valid_o,
  output logic [TAG_W-1:0]  req_tag_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [1:0]        req_kind_o,
  input  logic              cpl_valid_i,
  input  logic [TAG_W-1:0]  cpl_tag_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [ID_W-1:0]   r_id_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o,
  output logic              r_last_o
);
  localparam logic [2:0] BEAT_SIZE = 3'(OFF_W);

  // per-tag table
  logic [NTAG-1:0]  busy_q;
  logic [NTAG-1:0]  single_q;
  logic [LEN_W-1:0] len_q  [NTAG];
  logic [OFF_W-1:0] off_q  [NTAG];
  logic [ID_W-1:0]  id_q   [NTAG];
  logic [LEN_W:0]   rcv_q  [NTAG];

  logic             live_q, acc_q;
  logic [LEN_W-1:0] beat_q;

  logic             free_any;
  logic [TAG_W-1:0] free_tag;
  logic [TAG_W-1:0] hd_tag;
  logic             ord_empty;
  logic             accept, single_req, cpl_ok, r_fire, r_end;
  logic [LEN_W-1:0] eff_len;
  logic [DATA_W-1:0] cur_w, prev_w;

  rd_tag_alloc #(.NTAG(NTAG)) u_alloc (
    .busy_i (busy_q),
    .free_o (free_any),
    .tag_o  (free_tag)
  );

  // acceptance
  assign ar_ready_o = live_q & ~acc_q & ar_valid_i & credit_ok_i & free_any;
  assign accept     = ar_ready_o;
  assign single_req = is_single(ar_kind_i);
  assign eff_len    = single_req ? '0 : ar_len_i;

  assign proto_err_o = accept & ~single_req & (ar_len_i != '0) & (ar_size_i != BEAT_SIZE);

  assign req_valid_o = accept;
  assign req_tag_o   = free_tag;
  assign req_addr_o  = ar_addr_i;
  assign req_len_o   = eff_len;
  assign req_kind_o  = ar_kind_i;

  // completion intake
  assign cpl_ok = cpl_valid_i & busy_q[cpl_tag_i]
                & (rcv_q[cpl_tag_i] <= {1'b0, len_q[cpl_tag_i]});

  rd_cpl_buffer #(.NTAG(NTAG), .MAX_BEATS(MAX_BEATS), .DATA_W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (cpl_ok),
    .wtag_i  (cpl_tag_i),
    .widx_i  (rcv_q[cpl_tag_i][LEN_W-1:0]),
    .wdata_i (cpl_data_i),
    .rtag_i  (hd_tag),
    .ridx_i  (beat_q),
    .cur_o   (cur_w),
    .prev_o  (prev_w)
  );

  // playback order
  rd_order_fifo #(.N(NTAG), .W(TAG_W)) u_ord (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .tag_i   (free_tag),
    .pop_i   (r_end),
    .head_o  (hd_tag),
    .empty_o (ord_empty)
  );

  assign r_valid_o = ~ord_empty & ({1'b0, beat_q} < rcv_q[hd_tag]);
  assign r_last_o  = (beat_q == len_q[hd_tag]);
  assign r_id_o    = id_q[hd_tag];
  assign r_resp_o  = RESP_OKAY;
  assign r_fire    = r_valid_o & r_ready_i;
  assign r_end     = r_fire & r_last_o;

  rd_realign #(.DATA_W(DATA_W)) u_align (
    .single_i (single_q[hd_tag]),
    .off_i    (off_q[hd_tag]),
    .cur_i    (cur_w),
    .prev_i   (prev_w),
    .data_o   (r_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      acc_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      live_q <= 1'b1;
      acc_q  <= accept;
      if (r_end)       beat_q <= '0;
      else if (r_fire) beat_q <= beat_q + 1'b1;
    end
  end

  for (genvar t = 0; t < NTAG; t++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[t]   <= 1'b0;
        single_q[t] <= 1'b0;
        len_q[t]    <= '0;
        off_q[t]    <= '0;
        id_q[t]     <= '0;
        rcv_q[t]    <= '0;
      end else begin
        if (accept && free_tag == TAG_W'(t)) begin
          busy_q[t]   <= 1'b1;
          single_q[t] <= single_req;
          len_q[t]    <= eff_len;
          off_q[t]    <= ar_addr_i[OFF_W-1:0];
          id_q[t]     <= ar_id_i;
          rcv_q[t]    <= '0;
        end else begin
          if (r_end && hd_tag == TAG_W'(t)) busy_q[t] <= 1'b0;
          if (cpl_ok && cpl_tag_i == TAG_W'(t)) rcv_q[t] <= rcv_q[t] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/axi_split_rd_chk.sv
module axi_split_rd_chk #(
  parameter int NTAG   = 8,
  parameter int ID_W   = 4,
  parameter int DATA_W = 256,
  localparam int CW    = $clog2(NTAG + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ar_valid_i,
  input logic              ar_ready_o,
  input logic              credit_ok_i,
  input logic              proto_err_o,
  input logic              r_valid_o,
  input logic              r_ready_i,
  input logic              r_last_o,
  input logic [ID_W-1:0]   r_id_o,
  input logic [DATA_W-1:0] r_data_o,
  input logic [1:0]        r_resp_o
);
  logic [CW-1:0] outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else outst_q <= outst_q + CW'(ar_ready_o) - CW'(r_valid_o & r_ready_i & r_last_o);
  end

  a_r1_ready_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_ready_o |-> (ar_valid_i && credit_ok_i));

  a_r1_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_ready_o |=> !ar_ready_o);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_ready_o |-> (outst_q < CW'(NTAG)));

  a_r4_err_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> ar_ready_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |=>
      (r_valid_o && $stable(r_data_o) && $stable(r_last_o) && $stable(r_id_o)));

  a_r10_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o |-> (r_resp_o == 2'b00));

  a_r13_no_data_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outst_q == '0) |-> !r_valid_o);
endmodule

bind axi_split_rd_slave axi_split_rd_chk #(
  .NTAG(NTAG), .ID_W(ID_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ar_valid_i  (ar_valid_i),
  .ar_ready_o  (ar_ready_o),
  .credit_ok_i (credit_ok_i),
  .proto_err_o (proto_err_o),
  .r_valid_o   (r_valid_o),
  .r_ready_i   (r_ready_i),
  .r_last_o    (r_last_o),
  .r_id_o      (r_id_o),
  .r_data_o    (r_data_o),
  .r_resp_o    (r_resp_o)
);

// File: tb/tb_axi_split_rd_slave.sv
module tb_axi_split_rd_slave;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 4;
  localparam int DATA_W = 256;
  localparam int NTAG   = 8;
  localparam int MAXB   = 8;
  localparam int TAG_W  = 3;
  localparam int LEN_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ar_valid = 1'b0, ar_ready;
  logic [ID_W-1:0]   ar_id = '0;
  logic [ADDR_W-1:0] ar_addr = '0;
  logic [LEN_W-1:0]  ar_len = '0;
  logic [2:0]        ar_size = 3'd5;
  logic [1:0]        ar_kind = 2'd0;
  logic              credit = 1'b1;
  logic              proto_err, req_valid;
  logic [TAG_W-1:0]  req_tag;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [1:0]        req_kind;
  logic              cpl_valid = 1'b0;
  logic [TAG_W-1:0]  cpl_tag = '0;
  logic [DATA_W-1:0] cpl_data = '0;
  logic              r_valid, r_last;
  logic              r_ready = 1'b0;
  logic [ID_W-1:0]   r_id;
  logic [DATA_W-1:0] r_data;
  logic [1:0]        r_resp;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  axi_split_rd_slave #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .NTAG(NTAG), .MAX_BEATS(MAXB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ar_valid_i(ar_valid), .ar_ready_o(ar_ready), .ar_id_i(ar_id), .ar_addr_i(ar_addr),
    .ar_len_i(ar_len), .ar_size_i(ar_size), .ar_kind_i(ar_kind), .credit_ok_i(credit),
    .proto_err_o(proto_err), .req_valid_o(req_valid), .req_tag_o(req_tag),
    .req_addr_o(req_addr), .req_len_o(req_len), .req_kind_o(req_kind),
    .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag), .cpl_data_i(cpl_data),
    .r_valid_o(r_valid), .r_ready_i(r_ready), .r_id_o(r_id), .r_data_o(r_data),
    .r_resp_o(r_resp), .r_last_o(r_last)
  );

  task automatic chk(input logic ok, input string rq, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mkw(input int s);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W / 32; i++) w[i*32 +: 32] = 32'(s * 16 + i) ^ 32'hA500_0000;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] algn(input logic [DATA_W-1:0] c,
      input logic [DATA_W-1:0] p, input int off);
    if (off == 0) return c;
    return (c << (8 * off)) | (p >> (DATA_W - 8 * off));
  endfunction

  task automatic do_req(input int id, input int addr, input int len, input int size,
                        input int kind, input int exp_tag, input int exp_len,
                        input logic exp_err, input string rq);
    int n = 0;
    @(negedge clk);
    ar_valid = 1'b1; ar_id = ID_W'(id); ar_addr = ADDR_W'(addr);
    ar_len = LEN_W'(len); ar_size = 3'(size); ar_kind = 2'(kind);
    #1;
    while (!ar_ready && n < 60) begin @(negedge clk); #1; n++; end
    chk(ar_ready && req_valid, rq, DATA_W'(ar_ready), 1);
    chk(req_tag == TAG_W'(exp_tag), "R2 tag", DATA_W'(req_tag), DATA_W'(exp_tag));
    chk(req_len == LEN_W'(exp_len) && req_addr == ADDR_W'(addr) && req_kind == 2'(kind),
        "R2 fields", DATA_W'({req_len, req_kind}), DATA_W'({LEN_W'(exp_len), 2'(kind)}));
    chk(proto_err == exp_err, "R4 proto_err", DATA_W'(proto_err), DATA_W'(exp_err));
    @(posedge clk); #1;
    ar_valid = 1'b0;
  endtask

  task automatic send(input int tag, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = TAG_W'(tag); cpl_data = d;
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  task automatic recv(input int id, input logic [DATA_W-1:0] d, input logic last,
                      input string rq);
    int n = 0;
    @(negedge clk);
    r_ready = 1'b1;
    #1;
    while (!r_valid && n < 60) begin @(negedge clk); #1; n++; end
    chk(r_valid, {rq, " valid"}, DATA_W'(r_valid), 1);
    chk(r_data == d, {rq, " data"}, r_data, d);
    chk(r_last == last, {rq, " R6 last"}, DATA_W'(r_last), DATA_W'(last));
    chk(r_id == ID_W'(id), {rq, " R5 id"}, DATA_W'(r_id), DATA_W'(id));
    chk(r_resp == 2'b00, "R10 resp", DATA_W'(r_resp), 0);
    @(posedge clk); #1;
    r_ready = 1'b0;
  endtask

  task automatic t_reset;
    ar_valid = 1'b1;
    #1;
    chk(!ar_ready && !r_valid, "R12 in reset", DATA_W'({ar_ready, r_valid}), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(!ar_ready && !r_valid, "R12 after reset", DATA_W'({ar_ready, r_valid}), 0);
    ar_valid = 1'b0;
  endtask

  task automatic t_credit;
    @(negedge clk);
    credit = 1'b0; ar_valid = 1'b1; ar_len = '0; ar_kind = 2'd0;
    for (int i = 0; i < 4; i++) begin
      #1 chk(!ar_ready, "R1 no credit", DATA_W'(ar_ready), 0);
      @(negedge clk);
    end
    ar_valid = 1'b0; credit = 1'b1;
    do_req(2, 32'h100, 0, 5, 0, 0, 0, 1'b0, "R1 credit accept");
    #1 chk(!ar_ready, "R1 single pulse", DATA_W'(ar_ready), 0);
    send(0, mkw(1));
    recv(2, mkw(1), 1'b1, "R6 single");
  endtask

  task automatic t_burst;
    do_req(5, 32'h2000, 3, 5, 0, 0, 3, 1'b0, "R2 burst");
    for (int k = 0; k < 4; k++) send(0, mkw(10 + k));
    for (int k = 0; k < 4; k++) recv(5, mkw(10 + k), k == 3, "R6 burst");
    #1 chk(!r_valid, "R6 no extra beat", DATA_W'(r_valid), 0);
  endtask

  task automatic t_align;
    do_req(6, 32'h3004, 1, 5, 0, 0, 1, 1'b0, "R8 req");
    send(0, mkw(20)); send(0, mkw(21));
    recv(6, algn(mkw(20), '0, 4), 1'b0, "R8 beat0");
    recv(6, algn(mkw(21), mkw(20), 4), 1'b1, "R8 beat1");
  endtask

  task automatic t_cfg;
    logic [DATA_W-1:0] e;
    do_req(7, 32'h48, 5, 2, 1, 0, 0, 1'b0, "R9 cfg req");
    send(0, mkw(30));
    e = {{(DATA_W - 32){1'b0}}, mkw(30)[31:0]} << 64;
    recv(7, e, 1'b1, "R9 cfg beat");
    do_req(8, 32'h4, 2, 1, 2, 0, 0, 1'b0, "R9 io req");
    send(0, mkw(31));
    e = {{(DATA_W - 32){1'b0}}, mkw(31)[31:0]} << 32;
    recv(8, e, 1'b1, "R9 io beat");
    #1 chk(!r_valid, "R9 one beat only", DATA_W'(r_valid), 0);
  endtask

  task automatic t_proto;
    do_req(9, 32'h0, 1, 3, 0, 0, 1, 1'b1, "R4 bad size");
    send(0, mkw(40)); send(0, mkw(41));
    recv(9, mkw(40), 1'b0, "R4 served b0");
    recv(9, mkw(41), 1'b1, "R4 served b1");
  endtask

  task automatic t_hold;
    logic [DATA_W-1:0] d0;
    do_req(3, 32'h0, 1, 5, 0, 0, 1, 1'b0, "R7 req");
    send(0, mkw(50)); send(0, mkw(51));
    @(negedge clk); #1 d0 = r_data;
    repeat (3) @(negedge clk);
    #1 chk(r_valid && r_data == d0 && !r_last && r_id == 4'd3, "R7 hold", r_data, d0);
    recv(3, mkw(50), 1'b0, "R7 b0");
    recv(3, mkw(51), 1'b1, "R7 b1");
  endtask

  task automatic t_order;
    do_req(3, 32'h0, 1, 5, 0, 0, 1, 1'b0, "R5 req A");
    do_req(5, 32'h0, 0, 5, 0, 1, 0, 1'b0, "R5 req B");
    send(1, mkw(60));
    @(negedge clk); #1 chk(!r_valid, "R13 B waits for A", DATA_W'(r_valid), 0);
    send(0, mkw(61));
    recv(3, mkw(61), 1'b0, "R5 A b0");
    @(negedge clk); #1 chk(!r_valid, "R13 beat1 not arrived", DATA_W'(r_valid), 0);
    send(0, mkw(62));
    recv(3, mkw(62), 1'b1, "R5 A b1");
    recv(5, mkw(60), 1'b1, "R5 B");
  endtask

  task automatic t_full;
    for (int i = 0; i < NTAG; i++) do_req(i, 32'h0, 0, 5, 0, i, 0, 1'b0, "R3 fill");
    @(negedge clk);
    ar_valid = 1'b1; ar_len = '0; ar_kind = 2'd0; ar_id = 4'd12;
    for (int i = 0; i < 3; i++) begin
      #1 chk(!ar_ready, "R3 full blocks", DATA_W'(ar_ready), 0);
      @(negedge clk);
    end
    ar_valid = 1'b0;
    send(3, mkw(73));
    @(negedge clk); #1 chk(!r_valid, "R5 tag3 behind tag0", DATA_W'(r_valid), 0);
    send(0, mkw(70));
    recv(0, mkw(70), 1'b1, "R3 drain tag0");
    do_req(12, 32'h0, 0, 5, 0, 0, 0, 1'b0, "R3 freed slot");
    for (int i = 1; i < NTAG; i++) if (i != 3) send(i, mkw(70 + i));
    send(0, mkw(80));
    for (int i = 1; i < NTAG; i++) recv(i, mkw(70 + i), 1'b1, "R3 drain");
    recv(12, mkw(80), 1'b1, "R3 drain last");
  endtask

  task automatic t_ignore;
    send(1, mkw(90));
    @(negedge clk); #1 chk(!r_valid, "R11 free tag ignored", DATA_W'(r_valid), 0);
    do_req(1, 32'h0, 0, 5, 0, 0, 0, 1'b0, "R11 req X");
    do_req(2, 32'h0, 0, 5, 0, 1, 0, 1'b0, "R11 req Y");
    send(0, mkw(91)); send(0, mkw(92)); send(1, mkw(93));
    recv(1, mkw(91), 1'b1, "R11 extra word dropped");
    recv(2, mkw(93), 1'b1, "R11 tag1 clean");
    @(negedge clk); #1 chk(!r_valid, "R11 no stray beat", DATA_W'(r_valid), 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_credit;
    t_burst;
    t_align;
    t_cfg;
    t_proto;
    t_hold;
    t_order;
    t_full;
    t_ignore;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule